// File: doc/BRIEF.md
# Serial Flash Read Command Slave

This block is the slave-side front end of a serial flash device that answers single-line array reads. A host selects it with an active-low chip select, then shifts in an 8-bit command byte, a 24-bit start address and, for the fast variant, eight ignored padding bits. After that the block streams bytes from an internal byte array on its serial output, one bit per serial clock. The read address advances by one after every byte and rolls over from the top of the array to zero. The host may raise chip select at any bit, and the output is then released at once.

All serial pins are brought into the system clock domain through a short synchronizer chain, and the serial clock edges are detected there. Input bits are taken on rising serial clock edges and output bits change after falling edges, so hosts that idle the serial clock low and hosts that idle it high are both served. The array is an inferable RAM. A separate load port fills it before use.

Top module: `flash_rd_slave`

## Requirements
- R1: After command byte 03h and 24 address bits, the first data bit is driven after the falling serial clock edge that directly follows the rising edge that took the last address bit.
- R2: After command byte 0Bh and 24 address bits, eight further serial clocks are ignored, and data starts after the falling edge that follows the last of them.
- R3: The command byte and the address are taken most significant bit first. Each data byte is sent from bit 7 down to bit 0.
- R4: Each completed data byte advances the read address by one, and the byte after address 2^ADDR_W-1 is the one at address 0, with no extra serial clock in between.
- R5: Address bits at positions ADDR_W and above are ignored.
- R6: spi_so_oe stays low during the command, address and padding phases, and spi_so reads 0 whenever spi_so_oe is low.
- R7: When spi_cs_n goes high at any bit, spi_so_oe is released within SYNC_STAGES+1 clock cycles. The next selection is then decoded from its first bit, whatever the last transfer was doing.
- R8: Any command byte other than 03h or 0Bh keeps spi_so_oe low until chip select goes high.
- R9: The serial clock level at the falling edge of chip select does not matter: transfers that idle the serial clock low and transfers that idle it high give the same data.
- R10: While rst is high, spi_so_oe and spi_so are 0.
- R11: When ld_we is high on a clock edge, ld_data is written to array entry ld_addr, and reads later return that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host, 0 when released |
| spi_so_oe | output | 1 | Drive enable for spi_so; low means high impedance |
| ld_we | input | 1 | Array load write enable |
| ld_addr | input | ADDR_W | Array load address |
| ld_data | input | 8 | Array load data byte |

## Verification
The assertions assume that every high and low phase of the serial clock lasts at least two system clocks after synchronization, and that chip select changes only while the serial clock is steady. Otherwise edges would merge or a byte would be cut between two detection windows. The bench drives each serial clock phase for four system clocks and changes every input shortly after a rising system clock edge. It moves chip select only between whole serial clock phases, and compares the outputs with its own model once the synchronizer latency has passed.

// File: rtl/frs_pkg.sv
package frs_pkg;
  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_BAD
  } phase_t;

  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_FAST   = 8'h0B;
  localparam int         ADDR_BITS = 24;
  localparam int         PAD_BITS  = 8;
  localparam int         CNT_W     = 5;
endpackage

// File: rtl/frs_spi_sync.sv
module frs_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic rise,
  output logic fall,
  output logic si_s,
  output logic cs_idle
);
  localparam int         NSIG     = 3;
  localparam logic [2:0] IDLE_LVL = 3'b100;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            sck_d;

  assign raw = {cs_n, sck, si};

  genvar g;
  for (g = 0; g < NSIG; g++) begin : g_sig
    logic [STAGES-1:0] chain;
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= IDLE_LVL[g];
        else     chain <= raw[g];
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE_LVL[g]}};
        else     chain <= {chain[STAGES-2:0], raw[g]};
      end
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= synced[1];
  end

  assign rise    = synced[1] & ~sck_d;
  assign fall    = ~synced[1] & sck_d;
  assign si_s    = synced[0];
  assign cs_idle = synced[2];

  // R9: a serial clock phase spans more than one detection cycle
  a_r9_phase_width: assert property (@(posedge clk) disable iff (rst)
    rise |=> !fall);
endmodule

// File: rtl/frs_cmd_fsm.sv
module frs_cmd_fsm
  import frs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              rise,
  input  logic              fall,
  input  logic              si,
  output logic              in_data,
  output logic [2:0]        bit_idx,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(7);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] PAD_LAST  = CNT_W'(PAD_BITS - 1);

  phase_t            ph;
  logic [CNT_W-1:0]  cnt;
  logic [6:0]        op_sr;
  logic [ADDR_W-1:0] ad_sr;
  logic              fast;
  logic [7:0]        op_next;
  logic [ADDR_W-1:0] ad_next;
  logic              rd_step;

  assign op_next = {op_sr, si};
  assign ad_next = {ad_sr[ADDR_W-2:0], si};
  assign in_data = (ph == PH_DATA);
  assign rd_step = fall && (ph == PH_DATA) && (bit_idx == 3'd7);

  always_ff @(posedge clk) begin
    if (clr) begin
      ph      <= PH_OPC;
      cnt     <= '0;
      op_sr   <= '0;
      ad_sr   <= '0;
      fast    <= 1'b0;
      bit_idx <= '0;
      rd_addr <= '0;
    end else if (rise) begin
      case (ph)
        PH_OPC: begin
          op_sr <= op_next[6:0];
          if (cnt == OPC_LAST) begin
            cnt  <= '0;
            fast <= (op_next == OP_FAST);
            ph   <= (op_next == OP_READ || op_next == OP_FAST) ? PH_ADDR : PH_BAD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ADDR: begin
          ad_sr <= ad_next;
          if (cnt == ADDR_LAST) begin
            cnt     <= '0;
            rd_addr <= ad_next;
            ph      <= fast ? PH_DUMMY : PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DUMMY: begin
          if (cnt == PAD_LAST) begin
            cnt <= '0;
            ph  <= PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end else if (fall && ph == PH_DATA) begin
      bit_idx <= bit_idx + 1'b1;
      if (bit_idx == 3'd7) rd_addr <= rd_addr + 1'b1;
    end
  end

  // R8: an unknown command keeps the block silent until deselect
  a_r8_bad_sticky: assert property (@(posedge clk) disable iff (clr)
    ph == PH_BAD |=> ph == PH_BAD);

  // R4: a finished byte moves the read pointer by one, rolling over
  a_r4_addr_step: assert property (@(posedge clk) disable iff (clr)
    rd_step |=> rd_addr == ADDR_W'($past(rd_addr) + 1'b1));

  // R3: address phase never overruns its 24 bits
  a_r3_addr_count: assert property (@(posedge clk) disable iff (clr)
    ph == PH_ADDR |-> cnt <= ADDR_LAST);
endmodule

// File: rtl/frs_byte_ram.sv
module frs_byte_ram #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
    rdata <= arr[raddr];
  end
endmodule

// File: rtl/frs_tx.sv
module frs_tx (
  input  logic       clk,
  input  logic       clr,
  input  logic       fall,
  input  logic       in_data,
  input  logic [2:0] bit_idx,
  input  logic [7:0] byte_q,
  output logic       so,
  output logic       so_oe
);
  always_ff @(posedge clk) begin
    if (clr) begin
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else if (fall && in_data) begin
      so    <= byte_q[3'd7 - bit_idx];
      so_oe <= 1'b1;
    end
  end

  // R6: released output reads zero
  a_r6_zero_when_off: assert property (@(posedge clk) disable iff (clr)
    !so_oe |-> !so);

  // R6: no drive outside the data phase
  a_r6_header_quiet: assert property (@(posedge clk) disable iff (clr)
    !in_data |-> !so_oe);

  // R1: the drive enable turns on only from the data phase
  a_r1_enable_from_data: assert property (@(posedge clk) disable iff (clr)
    $rose(so_oe) |-> $past(in_data));
endmodule

// File: rtl/flash_rd_slave.sv
module flash_rd_slave #(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_oe,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data
);
  logic              rise;
  logic              fall;
  logic              si_s;
  logic              cs_idle;
  logic              clr;
  logic              in_data;
  logic [2:0]        bit_idx;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        byte_q;

  assign clr = rst | cs_idle;

  frs_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .sck     (spi_sck),
    .cs_n    (spi_cs_n),
    .si      (spi_si),
    .rise    (rise),
    .fall    (fall),
    .si_s    (si_s),
    .cs_idle (cs_idle)
  );

  frs_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk     (clk),
    .clr     (clr),
    .rise    (rise),
    .fall    (fall),
    .si      (si_s),
    .in_data (in_data),
    .bit_idx (bit_idx),
    .rd_addr (rd_addr)
  );

  frs_byte_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (ld_we),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (rd_addr),
    .rdata (byte_q)
  );

  frs_tx u_tx (
    .clk     (clk),
    .clr     (clr),
    .fall    (fall),
    .in_data (in_data),
    .bit_idx (bit_idx),
    .byte_q  (byte_q),
    .so      (spi_so),
    .so_oe   (spi_so_oe)
  );

  // R7: a synchronized deselect releases the output on the next edge
  a_r7_deselect_release: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> !spi_so_oe);
endmodule

// File: tb/flash_rd_slave_test.sv
module flash_rd_slave_test;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HALF   = 4;
  localparam int SETTLE = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              spi_sck = 1'b0;
  logic              spi_cs_n = 1'b1;
  logic              spi_si = 1'b0;
  logic              spi_so;
  logic              spi_so_oe;
  logic              ld_we = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [7:0]        ld_data = '0;

  logic [7:0] ref_mem [DEPTH];
  int    n_cmp = 0;
  int    n_bad = 0;
  int    quiet = 0;
  logic  exp_oe = 1'b0;
  logic  exp_so = 1'b0;
  string cur_req = "R6";
  bit    finished = 1'b0;

  always #4 clk = ~clk;

  flash_rd_slave #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) uut (
    .clk       (clk),
    .rst       (rst),
    .spi_sck   (spi_sck),
    .spi_cs_n  (spi_cs_n),
    .spi_si    (spi_si),
    .spi_so    (spi_so),
    .spi_so_oe (spi_so_oe),
    .ld_we     (ld_we),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data)
  );

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (quiet > 0) begin
        quiet = quiet - 1;
      end else begin
        n_cmp++;
        if (spi_so_oe !== exp_oe || spi_so !== (exp_oe ? exp_so : 1'b0)) begin
          n_bad++;
          $display("FAIL %s: so_oe=%b so=%b expected so_oe=%b so=%b at %0t",
                   cur_req, spi_so_oe, spi_so, exp_oe, exp_oe ? exp_so : 1'b0, $time);
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  task automatic step();
    repeat (HALF) @(posedge clk);
    #2;
  endtask

  // R11: fill the array through the load port
  task automatic preload();
    for (int i = 0; i < DEPTH; i++) begin
      @(posedge clk); #2;
      ld_we   = 1'b1;
      ld_addr = ADDR_W'(i);
      ld_data = 8'((i * 37 + 11) ^ (i >> 3));
      ref_mem[i] = ld_data;
    end
    @(posedge clk); #2;
    ld_we = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] opc, input logic [23:0] adr,
                      input int stop_at, input int nbits, input bit idle_hi,
                      input string tag);
    logic [39:0] hv;
    bit          ok;
    int          hl;
    int          sent;
    logic [7:0]  cur;
    hv   = {opc, adr, 8'h00};
    ok   = (opc == 8'h03) || (opc == 8'h0B);
    hl   = !ok ? 8 : ((opc == 8'h0B) ? 40 : 32);
    sent = (stop_at < hl) ? stop_at : hl;
    spi_sck = idle_hi; quiet = SETTLE;
    step();
    spi_cs_n = 1'b0; quiet = SETTLE;
    cur_req = "R6";
    exp_oe = 1'b0;
    step();
    for (int i = 0; i < sent; i++) begin
      if (spi_sck) begin spi_sck = 1'b0; quiet = SETTLE; end
      spi_si = hv[39 - i];
      step();
      spi_sck = 1'b1; quiet = SETTLE;
      step();
    end
    if (sent == hl) begin
      for (int b = 0; b < nbits; b++) begin
        spi_sck = 1'b0;
        spi_si  = b[0];
        if (ok) begin
          cur_req = tag;
          cur     = ref_mem[(int'(adr) + b / 8) % DEPTH];
          exp_oe  = 1'b1;
          exp_so  = cur[7 - (b % 8)];
        end else begin
          cur_req = "R8";
        end
        quiet = SETTLE;
        step();
        spi_sck = 1'b1; quiet = SETTLE;
        step();
      end
    end
    spi_cs_n = 1'b1; quiet = SETTLE;
    cur_req = "R7";
    exp_oe  = 1'b0;
    step();
    spi_sck = 1'b0; quiet = SETTLE;
    step();
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (spi_so_oe !== 1'b0 || spi_so !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: so_oe=%b so=%b expected so_oe=0 so=0", spi_so_oe, spi_so);
    end
    preload();
    @(posedge clk); #2;
    rst = 1'b0;
    step();
    // R1 R3 R11: plain read, serial clock idling low
    xfer(8'h03, 24'h000010, 99, 24, 1'b0, "R1 R3 R11");
    // R2 R9: fast read, serial clock idling high
    xfer(8'h0B, 24'h000040, 99, 16, 1'b1, "R2 R9");
    // R4: roll over from the top entry to entry zero
    xfer(8'h03, 24'h0000FE, 99, 32, 1'b0, "R4");
    xfer(8'h0B, 24'h0000FF, 99, 16, 1'b1, "R4");
    // R5: upper address bits are dropped
    xfer(8'h0B, 24'hA5C333, 99, 16, 1'b0, "R5");
    xfer(8'h03, 24'hFFFF07, 99, 8, 1'b1, "R5");
    // R7: stop mid-byte, then a fresh transfer must decode normally
    xfer(8'h03, 24'h000020, 99, 11, 1'b0, "R7");
    xfer(8'h03, 24'h000021, 99, 10, 1'b1, "R7");
    // R7: stop inside the address and inside the padding byte
    xfer(8'h0B, 24'h000055, 20, 0, 1'b0, "R7");
    xfer(8'h0B, 24'h000055, 35, 0, 1'b1, "R7");
    xfer(8'h03, 24'h000055, 99, 8, 1'b0, "R7");
    // R8: unknown command stays silent while clocked
    xfer(8'h9F, 24'h000000, 99, 48, 1'b0, "R8");
    xfer(8'h3B, 24'h000000, 99, 24, 1'b1, "R8");
    // R9: same bytes regardless of idle level
    xfer(8'h03, 24'h000080, 99, 8, 1'b1, "R9");
    xfer(8'h03, 24'h000080, 99, 8, 1'b0, "R9");
    summary();
    $finish;
  end
endmodule